// File: doc/BRIEF.md
# Phase-Two Continuation Command Sequencer

This block drives the second stage of elliptic-curve factoring without doing any arithmetic itself. It walks a bit table row by row, from a lower row index to an upper row index. Each set bit in a row marks a precomputed point multiple that has to be folded into the running product. For every step the block issues a command word: fetch a point multiple, run one of a fixed set of modular products or differences, reset the accumulator, or add the fixed step point to the row point. Arithmetic units downstream consume these commands.

Positions in a row are taken in pairs. The difference r−s from one group is only issued inside the next group, so each run has exactly one leading multiply pair. A position left alone before the row ends gets a short closing group. Each row end produces one point-addition command. After the last row, one closing difference and one closing multiply are issued and the block raises its completion flag.

The table is read through a simple request port with a latency of one cycle. Commands leave on a valid/ready handshake. The row spacing used by the surrounding system is 210, but the block itself only sees row indices and bit positions.

Top module: `p2_cont_seq`

## Requirements
- R1: During reset and right after it, `tbl_rd_o`, `cmd_valid_o` and `done_o` are low.
- R2: `start_i` is accepted only while the block is idle or done, and it latches `row_first_i` and `row_last_i` at that point. A `start_i` seen while a run is in progress has no effect on the command stream.
- R3: A table read is a one-cycle `tbl_rd_o` pulse with `tbl_addr_o` set to the row. `tbl_row_i` is sampled on the next clock. Rows are read once each, in ascending order, from the first row up to the last row.
- R4: A command is a 4-bit opcode plus a position field. The encodings are: 0 fetch A, 1 fetch B, 2 r←Az·Rx, 3 s←Ax·Rz, 4 t←Az·Rx, 5 u←Ax·Rz, 6 d1←r−s, 7 d̃←d·d1, 8 r←Bz·Rx, 9 d2←t−u, 10 d←d̃·d2, 11 s←Bx·Rz, 12 d←1, 13 d←d·d1, 14 R←R+Q. The position field holds the bit index for opcodes 0 and 1 and is zero for all other opcodes.
- R5: While `cmd_valid_o` is high and `cmd_ready_i` is low, the opcode and the position field stay unchanged.
- R6: The first set position a of the run produces the opening group 0(a), 2, 3, 12.
- R7: Two further positions a<b in one row produce the paired group 0(a), 1(b), 4, 5, 6, 7, 8, 9, 10, 11.
- R8: A single remaining position a in a row produces the group 0(a), 2, 3, 6, 13.
- R9: Each row end, including the end of a row with no set bits, produces one command 14. When the table holds no position yet, empty rows are skipped this way until a position is found.
- R10: After the row end of the last row, the block issues 6 and then 13, and then raises `done_o`.
- R11: If no row holds a set bit, or if the first row index is greater than the last, the block issues a single command 12 after the row ends and then raises `done_o`.
- R12: `done_o` stays high and no command is offered until the next accepted `start_i`.
- R13: Positions within a row are used in ascending bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run |
| row_first_i | input | MW | First row index of the run |
| row_last_i | input | MW | Last row index of the run |
| tbl_rd_o | output | 1 | Table read request |
| tbl_addr_o | output | MW | Row index being read |
| tbl_row_i | input | ROW_W | Row bits, valid one cycle after the request |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command accepted by the consumer |
| cmd_op_o | output | 4 | Command opcode |
| cmd_pos_o | output | PW | Bit position for fetch commands |
| done_o | output | 1 | Run complete |

## Verification
The hardest situation to reach is a run where the first row, or several leading rows, contain no set bit, because the opening group must then slide past row-end commands into a later row. If every row stays empty, the closing group has to be replaced by the single accumulator reset. Directed tables place empty rows at the start, in the middle and throughout a run. A start pulse is also injected mid-run while the consumer randomly withholds ready. Random sparse tables then mix odd and even position counts per row, and a behavioural model in the bench checks every accepted command against its own queue.

// File: rtl/p2seq_pkg.sv
package p2seq_pkg;

   typedef enum logic [3:0] {
      OP_FETCH_A  = 4'd0,
      OP_FETCH_B  = 4'd1,
      OP_R_AZRX   = 4'd2,
      OP_S_AXRZ   = 4'd3,
      OP_T_AZRX   = 4'd4,
      OP_U_AXRZ   = 4'd5,
      OP_D1_RS    = 4'd6,
      OP_DT_DD1   = 4'd7,
      OP_R_BZRX   = 4'd8,
      OP_D2_TU    = 4'd9,
      OP_D_DTD2   = 4'd10,
      OP_S_BXRZ   = 4'd11,
      OP_D_ONE    = 4'd12,
      OP_D_DD1    = 4'd13,
      OP_PADD     = 4'd14
   } p2_op_e;

   typedef enum logic [2:0] {
      SQ_INIT,
      SQ_PAIR,
      SQ_SINGLE,
      SQ_ROWEND,
      SQ_FINAL,
      SQ_EMPTY
   } p2_grp_e;

   localparam int STEP_W = 4;

endpackage

// File: rtl/p2_lsb_find.sv
module p2_lsb_find #(
   parameter int W  = 24,
   localparam int PW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  bits_i,
   output logic [PW-1:0] pos_o,
   output logic          hit_o
);
   always_comb begin
      pos_o = '0;
      hit_o = |bits_i;
      for (int i = W - 1; i >= 0; i--) begin
         if (bits_i[i]) pos_o = PW'(i);
      end
   end
endmodule

// File: rtl/p2_grp_rom.sv
module p2_grp_rom
   import p2seq_pkg::*;
(
   input  p2_grp_e           grp_i,
   input  logic [STEP_W-1:0] step_i,
   output p2_op_e            op_o,
   output logic              last_o
);
   logic [STEP_W-1:0] len_m1;

   always_comb begin
      op_o   = OP_D_ONE;
      len_m1 = '0;
      unique case (grp_i)
         SQ_INIT: begin
            len_m1 = STEP_W'(3);
            case (step_i)
               4'd0:    op_o = OP_FETCH_A;
               4'd1:    op_o = OP_R_AZRX;
               4'd2:    op_o = OP_S_AXRZ;
               default: op_o = OP_D_ONE;
            endcase
         end
         SQ_PAIR: begin
            len_m1 = STEP_W'(9);
            case (step_i)
               4'd0:    op_o = OP_FETCH_A;
               4'd1:    op_o = OP_FETCH_B;
               4'd2:    op_o = OP_T_AZRX;
               4'd3:    op_o = OP_U_AXRZ;
               4'd4:    op_o = OP_D1_RS;
               4'd5:    op_o = OP_DT_DD1;
               4'd6:    op_o = OP_R_BZRX;
               4'd7:    op_o = OP_D2_TU;
               4'd8:    op_o = OP_D_DTD2;
               default: op_o = OP_S_BXRZ;
            endcase
         end
         SQ_SINGLE: begin
            len_m1 = STEP_W'(4);
            case (step_i)
               4'd0:    op_o = OP_FETCH_A;
               4'd1:    op_o = OP_R_AZRX;
               4'd2:    op_o = OP_S_AXRZ;
               4'd3:    op_o = OP_D1_RS;
               default: op_o = OP_D_DD1;
            endcase
         end
         SQ_ROWEND: op_o = OP_PADD;
         SQ_FINAL: begin
            len_m1 = STEP_W'(1);
            op_o   = (step_i == '0) ? OP_D1_RS : OP_D_DD1;
         end
         default:   op_o = OP_D_ONE;
      endcase
      last_o = (step_i == len_m1);
   end
endmodule

// File: rtl/p2_cont_seq.sv
module p2_cont_seq
   import p2seq_pkg::*;
#(
   parameter int ROW_W = 24,
   parameter int MW    = 8,
   localparam int PW   = (ROW_W > 1) ? $clog2(ROW_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [MW-1:0]    row_first_i,
   input  logic [MW-1:0]    row_last_i,
   output logic             tbl_rd_o,
   output logic [MW-1:0]    tbl_addr_o,
   input  logic [ROW_W-1:0] tbl_row_i,
   output logic             cmd_valid_o,
   input  logic             cmd_ready_i,
   output logic [3:0]       cmd_op_o,
   output logic [PW-1:0]    cmd_pos_o,
   output logic             done_o
);
   localparam logic [ROW_W-1:0] BIT0 = ROW_W'(1);

   generate
      if (ROW_W < 2 || ROW_W > 1024) begin : g_bad_row
         $error("p2_cont_seq: ROW_W out of range");
      end
      if (MW < 1) begin : g_bad_mw
         $error("p2_cont_seq: MW must be positive");
      end
   endgenerate

   typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_LOAD, ST_SCAN, ST_EMIT, ST_DONE} st_e;

   st_e               st_q;
   logic [MW-1:0]     m_q, mmin_q, mmax_q;
   logic [ROW_W-1:0]  row_q;
   logic              first_q;
   p2_grp_e           grp_q;
   logic [STEP_W-1:0] step_q;
   logic [PW-1:0]     pos_a_q, pos_b_q;

   logic [PW-1:0]     lo_pos, nx_pos;
   logic              lo_hit, nx_hit;
   logic [ROW_W-1:0]  row_less;
   p2_op_e            rom_op;
   logic              rom_last;
   logic              busy;

   assign row_less = row_q & ~(BIT0 << lo_pos);

   p2_lsb_find #(.W(ROW_W)) u_find_lo (.bits_i(row_q),    .pos_o(lo_pos), .hit_o(lo_hit));
   p2_lsb_find #(.W(ROW_W)) u_find_nx (.bits_i(row_less), .pos_o(nx_pos), .hit_o(nx_hit));
   p2_grp_rom u_rom (.grp_i(grp_q), .step_i(step_q), .op_o(rom_op), .last_o(rom_last));

   assign busy        = (st_q != ST_IDLE) && (st_q != ST_DONE);
   assign tbl_rd_o    = (st_q == ST_READ);
   assign tbl_addr_o  = m_q;
   assign cmd_valid_o = (st_q == ST_EMIT);
   assign cmd_op_o    = rom_op;
   assign cmd_pos_o   = (rom_op == OP_FETCH_A) ? pos_a_q :
                        (rom_op == OP_FETCH_B) ? pos_b_q : '0;
   assign done_o      = (st_q == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         m_q     <= '0;
         mmin_q  <= '0;
         mmax_q  <= '0;
         row_q   <= '0;
         first_q <= 1'b1;
         grp_q   <= SQ_INIT;
         step_q  <= '0;
         pos_a_q <= '0;
         pos_b_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_DONE: begin
               if (start_i) begin
                  mmin_q  <= row_first_i;
                  mmax_q  <= row_last_i;
                  m_q     <= row_first_i;
                  first_q <= 1'b1;
                  step_q  <= '0;
                  if (row_first_i > row_last_i) begin
                     grp_q <= SQ_EMPTY;
                     st_q  <= ST_EMIT;
                  end else begin
                     st_q  <= ST_READ;
                  end
               end
            end
            ST_READ: st_q <= ST_LOAD;
            ST_LOAD: begin
               row_q <= tbl_row_i;
               st_q  <= ST_SCAN;
            end
            ST_SCAN: begin
               step_q <= '0;
               st_q   <= ST_EMIT;
               if (!lo_hit) begin
                  grp_q <= SQ_ROWEND;
               end else if (first_q) begin
                  pos_a_q <= lo_pos;
                  row_q   <= row_less;
                  first_q <= 1'b0;
                  grp_q   <= SQ_INIT;
               end else if (nx_hit) begin
                  pos_a_q <= lo_pos;
                  pos_b_q <= nx_pos;
                  row_q   <= row_less & ~(BIT0 << nx_pos);
                  grp_q   <= SQ_PAIR;
               end else begin
                  pos_a_q <= lo_pos;
                  row_q   <= row_less;
                  grp_q   <= SQ_SINGLE;
               end
            end
            ST_EMIT: begin
               if (cmd_ready_i) begin
                  if (!rom_last) begin
                     step_q <= step_q + 1'b1;
                  end else begin
                     step_q <= '0;
                     unique case (grp_q)
                        SQ_ROWEND: begin
                           if (m_q == mmax_q) begin
                              grp_q <= first_q ? SQ_EMPTY : SQ_FINAL;
                           end else begin
                              m_q  <= m_q + 1'b1;
                              st_q <= ST_READ;
                           end
                        end
                        SQ_FINAL, SQ_EMPTY: st_q <= ST_DONE;
                        default:            st_q <= ST_SCAN;
                     endcase
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R5
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_pos_o)));

   // R3
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_rd_o |-> (tbl_addr_o >= mmin_q && tbl_addr_o <= mmax_q));

   // R3
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_rd_o |=> !tbl_rd_o);

   // R10
   done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(cmd_valid_o && cmd_ready_i));

   // R2
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> ($stable(mmin_q) && $stable(mmax_q)));

   // R12
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && !cmd_valid_o && !tbl_rd_o));

endmodule

// File: tb/p2_cont_seq_tb.sv
module p2_cont_seq_tb;
   localparam int ROW_W = 24;
   localparam int MW    = 8;
   localparam int PW    = $clog2(ROW_W);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [MW-1:0]    row_first_i = '0, row_last_i = '0;
   logic             tbl_rd_o;
   logic [MW-1:0]    tbl_addr_o;
   logic [ROW_W-1:0] tbl_row_i = '0;
   logic             cmd_valid_o;
   logic             cmd_ready_i = 1'b0;
   logic [3:0]       cmd_op_o;
   logic [PW-1:0]    cmd_pos_o;
   logic             done_o;

   p2_cont_seq #(.ROW_W(ROW_W), .MW(MW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .row_first_i(row_first_i), .row_last_i(row_last_i),
      .tbl_rd_o(tbl_rd_o), .tbl_addr_o(tbl_addr_o), .tbl_row_i(tbl_row_i),
      .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
      .cmd_op_o(cmd_op_o), .cmd_pos_o(cmd_pos_o), .done_o(done_o));

   logic [ROW_W-1:0] tab [0:(1<<MW)-1];
   always @(posedge clk) if (tbl_rd_o) tbl_row_i <= tab[tbl_addr_o];

   int    checks = 0, errors = 0, cycles = 0;
   int    eop[$], epos[$], erd[$];
   string tag = "R1";
   bit    ready_rand = 1'b0;
   bit    finished = 1'b0;

   task automatic chk(bit ok, string t, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", t, act, exp);
      end
   endtask

   task automatic push(int op, int pos);
      eop.push_back(op);
      epos.push_back(pos);
   endtask

   function automatic int lowest(logic [ROW_W-1:0] v);
      for (int i = 0; i < ROW_W; i++) if (v[i]) return i;
      return -1;
   endfunction

   // behavioural model of the expected command and read streams
   task automatic build(int lo, int hi);
      int m; bit first; logic [ROW_W-1:0] row; int a, b;
      eop.delete(); epos.delete(); erd.delete();
      if (lo > hi) begin push(12, 0); return; end
      m = lo; first = 1; erd.push_back(m); row = tab[m];
      forever begin
         a = lowest(row);
         if (a < 0) begin
            push(14, 0);
            if (m == hi) begin
               if (first) push(12, 0);
               else begin push(6, 0); push(13, 0); end
               return;
            end
            m++; erd.push_back(m); row = tab[m];
         end else begin
            row[a] = 1'b0;
            if (first) begin
               first = 0;
               push(0, a); push(2, 0); push(3, 0); push(12, 0);
            end else begin
               b = lowest(row);
               if (b >= 0) begin
                  row[b] = 1'b0;
                  push(0, a); push(1, b);
                  for (int k = 4; k <= 11; k++) push(k, 0);
               end else begin
                  push(0, a); push(2, 0); push(3, 0); push(6, 0); push(13, 0);
               end
            end
         end
      end
   endtask

   // per-clock comparison against the model
   initial begin
      bit   pend = 0;
      logic [3:0] pop_op; logic [PW-1:0] pop_pos;
      forever begin
         @(negedge clk);
         cmd_ready_i = ready_rand ? (($urandom % 3) != 0) : 1'b1;
         #1;
         if (rst_n) begin
            if (pend)
               chk(cmd_valid_o && cmd_op_o == pop_op && cmd_pos_o == pop_pos,
                   "R5 hold", int'(cmd_op_o), int'(pop_op));
            pend = cmd_valid_o && !cmd_ready_i;
            pop_op = cmd_op_o; pop_pos = cmd_pos_o;
            if (cmd_valid_o && cmd_ready_i) begin
               if (eop.size() == 0) chk(0, {tag, " R12 extra cmd"}, int'(cmd_op_o), -1);
               else begin
                  int xo, xp;
                  xo = eop.pop_front(); xp = epos.pop_front();
                  chk(int'(cmd_op_o) == xo, {tag, " R4 op"}, int'(cmd_op_o), xo);
                  chk(int'(cmd_pos_o) == xp, {tag, " R4 R13 pos"}, int'(cmd_pos_o), xp);
               end
            end
            if (tbl_rd_o) begin
               if (erd.size() == 0) chk(0, "R3 extra read", int'(tbl_addr_o), -1);
               else begin
                  int xr;
                  xr = erd.pop_front();
                  chk(int'(tbl_addr_o) == xr, "R3 read addr", int'(tbl_addr_o), xr);
               end
            end
         end
      end
   end

   task automatic run(int lo, int hi, string t, bit inject);
      int n;
      tag = t;
      build(lo, hi);
      @(negedge clk);
      start_i = 1'b1; row_first_i = MW'(lo); row_last_i = MW'(hi);
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      while (!done_o && n < 20000) begin
         @(negedge clk);
         n++;
         if (inject && n == 12) begin
            // R2: a start pulse while busy must leave the stream unchanged
            start_i = 1'b1; row_first_i = '0; row_last_i = '0;
            @(negedge clk);
            start_i = 1'b0;
         end
      end
      #2;
      chk(done_o, {t, " R10 done"}, int'(done_o), 1);
      chk(eop.size() == 0, {t, " R10 R11 all cmds"}, eop.size(), 0);
      chk(erd.size() == 0, {t, " R3 all reads"}, erd.size(), 0);
      repeat (4) @(negedge clk);
      #2;
      chk(done_o && !cmd_valid_o, {t, " R12 done held"}, int'(done_o), 1);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      for (int i = 0; i < (1 << MW); i++) tab[i] = '0;
      repeat (3) @(negedge clk);
      #1;
      // R1
      chk(!tbl_rd_o && !cmd_valid_o && !done_o, "R1 reset", int'(cmd_valid_o), 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!tbl_rd_o && !cmd_valid_o && !done_o, "R1 after reset", int'(done_o), 0);

      // R6 R7 R8 R9 R13: odd row, empty middle row, even row
      tab[3] = 24'h000491; tab[4] = '0; tab[5] = 24'h800002;
      run(3, 5, "R6 R7 R8 R9", 0);
      // R9: leading empty rows before the opening group
      tab[10] = '0; tab[11] = '0; tab[12] = 24'h000030; tab[13] = 24'h000100;
      run(10, 13, "R9 skip", 0);
      // R11: all rows empty
      tab[20] = '0; tab[21] = '0;
      run(20, 21, "R11 empty", 0);
      // R11: reversed range
      run(9, 4, "R11 reversed", 0);
      // R8: single row, one position
      tab[30] = 24'h000400;
      run(30, 30, "R8 one", 0);
      // R13: full row with handshake stalls
      ready_rand = 1'b1;
      tab[40] = '1; tab[41] = 24'h555555; tab[42] = 24'h000001;
      run(40, 42, "R7 R13 full", 0);
      // R2: start while busy
      run(40, 42, "R2 ignored", 1);
      // random sparse tables
      for (int r = 0; r < 20; r++) begin
         int lo, hi;
         lo = 50 + ($urandom % 100); hi = lo + ($urandom % 8);
         for (int m = lo; m <= hi; m++)
            tab[m] = (($urandom % 4) == 0) ? '0 : ROW_W'($urandom & $urandom & $urandom);
         run(lo, hi, "R7 R8 R9 random", 0);
      end
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule